// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channels

This block holds a small set of independent down-counting timer channels behind a word-wide register port. Each channel has a control word, an initial-count word and a read-only live-count word. A channel counts down on a divided version of the block clock. When it reaches zero it raises a pending flag in one status word that all channels share. It then either reloads and keeps going (periodic) or stops (one-shot).

Software arms a channel by loading the initial count and then setting the enable bit. A channel can be paused and resumed without losing its count, and it can be re-armed with the self-clearing reload bit. The division rate can be changed in flight. Each channel drives one interrupt line. The line is the channel's pending flag qualified by its own interrupt-enable bit.

Top module: `tmr_ctrl`

## Requirements
- R1: After reset, every control word reads 0x00000005, the initial and live counts read 0, the status word reads 0 and all interrupt lines are low.
- R2: An enabled channel decrements its live count once every (P + 1) clock cycles, where P is control bits 7:0. The division phase restarts on every write to that channel's control or initial-count word.
- R3: In one-shot mode (control bit 27 = 0), the step that takes the count to zero sets the channel's status bit, leaves the count at 0, and clears enable (bit 30) and active (bit 25).
- R4: In periodic mode (control bit 27 = 1), the step that reaches zero sets the status bit, reloads the live count from the initial count, and keeps the channel enabled.
- R5: Clearing enable freezes the live count. Setting enable again resumes from the frozen value.
- R6: A control write with the reload bit (bit 26) set copies the initial count into the live count. The same write drops enable, so the channel stops. Bit 26 always reads 0.
- R7: Active (bit 25) ignores writes and follows enable. Bits 24:8, 28 and 31 read as 0 whatever was written.
- R8: Changing P while running keeps the live count. Only the step rate afterwards changes.
- R9: Writing the initial-count word loads the live count at once. Writes to the live-count word have no effect.
- R10: Interrupt line i is high exactly when channel i's interrupt enable (bit 29) and its status bit are both set. It follows changes of either with no extra delay.
- R11: Writing 1 to status bit i clears it, and writing 0 leaves it alone. A zero event in the same cycle as the clear wins, so the bit stays set.
- R12: Clearing enable while the count is already 0 raises the zero event.
- R13: Channel i sits at byte offset 16*i: control at +0x0, initial count at +0x4, live count at +0x8. The status word is at 0x80. Unaligned, unmapped or absent-channel offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the reference for counting |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The counting function is driven with divide ratios of 1, 2, 4 and 256, with initial counts of 0, 1, 3, 5, 10 and 20, and in both one-shot and periodic mode. This separates an off-by-one in the divider from an off-by-one in the zero detect. A pause-then-resume run and a mid-count change of ratio show that the live count is held and not reloaded. An initial count of 1 in periodic mode puts a zero event on every cycle, so a status clear lands on the same edge as a new event and the priority between them shows. The reload-with-enable write and the disable-at-zero write are the two control-word cases where one write both changes the mode and touches the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // Control word fields; positions are fixed by software
   localparam int B_EN   = 30;
   localparam int B_IE   = 29;
   localparam int B_PER  = 27;
   localparam int B_RLD  = 26;
   localparam int B_ACT  = 25;
   localparam int PS_W   = 8;
   localparam logic [PS_W-1:0] PS_RESET = 8'h05;

   typedef enum logic [1:0] {
      RG_CTRL = 2'd0,
      RG_INIT = 2'd1,
      RG_CNT  = 2'd2,
      RG_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            restart,
   input  logic [PS_W-1:0] limit,
   output logic            tick
);
   logic [PS_W-1:0] div_q;

   assign tick = run && !restart && (div_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n)        div_q <= '0;
      else if (restart)  div_q <= '0;
      else if (run)      div_q <= tick ? '0 : div_q + 1'b1;
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic             init_we,
   input  logic [31:0]      wdata,
   output logic [31:0]      ctrl_rd,
   output logic [CNT_W-1:0] init_rd,
   output logic [CNT_W-1:0] cnt_rd,
   output logic             en_o,
   output logic             ie_o,
   output logic             zero_o
);
   logic            en_q, ie_q, per_q, act_q;
   logic [PS_W-1:0] ps_q;
   logic [CNT_W-1:0] init_q, cnt_q;
   logic            tick, new_en, stop_zero, run_zero;

   assign new_en    = wdata[B_EN] & ~wdata[B_RLD];
   assign stop_zero = ctrl_we && en_q && !new_en &&
                      (wdata[B_RLD] ? (init_q == '0) : (cnt_q == '0));
   assign run_zero  = tick && (cnt_q <= CNT_W'(1));
   assign zero_o    = stop_zero | run_zero;

   tmr_prescale #(.PS_W(PS_W)) u_ps (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .restart (ctrl_we | init_we),
      .limit   (ps_q),
      .tick    (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ie_q   <= 1'b0;
         per_q  <= 1'b0;
         act_q  <= 1'b0;
         ps_q   <= PS_RESET;
         init_q <= '0;
         cnt_q  <= '0;
      end else if (ctrl_we) begin
         en_q  <= new_en;
         act_q <= new_en;
         ie_q  <= wdata[B_IE];
         per_q <= wdata[B_PER];
         ps_q  <= wdata[PS_W-1:0];
         if (wdata[B_RLD] || (stop_zero && wdata[B_PER]))
            cnt_q <= init_q;
      end else if (init_we) begin
         init_q <= wdata[CNT_W-1:0];
         cnt_q  <= wdata[CNT_W-1:0];
      end else if (run_zero) begin
         if (per_q) begin
            cnt_q <= init_q;
         end else begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            act_q <= 1'b0;
         end
      end else if (tick) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      ctrl_rd              = '0;
      ctrl_rd[B_EN]        = en_q;
      ctrl_rd[B_IE]        = ie_q;
      ctrl_rd[B_PER]       = per_q;
      ctrl_rd[B_ACT]       = act_q;
      ctrl_rd[PS_W-1:0]    = ps_q;
   end

   assign init_rd = init_q;
   assign cnt_rd  = cnt_q;
   assign en_o    = en_q;
   assign ie_o    = ie_q;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 24,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int IDX_W = 3;
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(8'h80);

   if (NUM_CH < 1 || NUM_CH > (1 << IDX_W)) begin : g_bad_ch
      $error("NUM_CH out of range");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   logic             aligned, in_ch, is_stat;
   logic [IDX_W-1:0] idx;
   reg_sel_e         sub;
   logic [NUM_CH-1:0] ch_hit, ch_en, ch_ie, ch_evt, stat_q, stat_clr;
   logic [31:0]       ctrl_rd [NUM_CH];
   logic [CNT_W-1:0]  init_rd [NUM_CH];
   logic [CNT_W-1:0]  cnt_rd  [NUM_CH];

   assign aligned = (bus_addr[1:0] == 2'b00);
   assign in_ch   = aligned && (bus_addr[ADDR_W-1:7] == '0);
   assign is_stat = aligned && (bus_addr == STAT_ADDR);
   assign idx     = bus_addr[6:4];
   assign sub     = reg_sel_e'(bus_addr[3:2]);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      assign ch_hit[g] = in_ch && (int'(idx) == g);

      tmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctrl_we (bus_wr && ch_hit[g] && (sub == RG_CTRL)),
         .init_we (bus_wr && ch_hit[g] && (sub == RG_INIT)),
         .wdata   (bus_wdata),
         .ctrl_rd (ctrl_rd[g]),
         .init_rd (init_rd[g]),
         .cnt_rd  (cnt_rd[g]),
         .en_o    (ch_en[g]),
         .ie_o    (ch_ie[g]),
         .zero_o  (ch_evt[g])
      );
   end

   assign stat_clr = (bus_wr && is_stat) ? bus_wdata[NUM_CH-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~stat_clr) | ch_evt;
   end

   assign irq = ch_ie & stat_q;

   always_comb begin
      bus_rdata = '0;
      if (is_stat) begin
         bus_rdata[NUM_CH-1:0] = stat_q;
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) begin
               case (sub)
                  RG_CTRL: bus_rdata = ctrl_rd[i];
                  RG_INIT: bus_rdata = 32'(init_rd[i]);
                  RG_CNT:  bus_rdata = 32'(cnt_rd[i]);
                  default: bus_rdata = '0;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/tmr_ctrl_chk.sv
module tmr_ctrl_chk #(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [NUM_CH-1:0] irq,
   input logic [NUM_CH-1:0] stat_q,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] ch_evt,
   input logic [CNT_W-1:0]  cnt0
);
   // R11
   stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ch_evt)) == '0));

   // R7
   en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((ch_en & ~$past(ch_en)) == '0) || $past(bus_wr)));

   // R3
   en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((~ch_en & $past(ch_en)) == '0) || $past(bus_wr) ||
                ($past(ch_evt) != '0)));

   // R10
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((irq & ~$past(irq)) == '0) || $past(bus_wr) ||
                ($past(ch_evt) != '0)));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[0] && !bus_wr) |=> $stable(cnt0));
endmodule

bind tmr_ctrl tmr_ctrl_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .bus_wr (bus_wr),
   .irq    (irq),
   .stat_q (stat_q),
   .ch_en  (ch_en),
   .ch_evt (ch_evt),
   .cnt0   (cnt_rd[0])
);

// File: tb/tb_tmr_ctrl.sv
module tb_tmr_ctrl;
   localparam int NUM_CH = 3;
   localparam int CNT_W  = 24;
   localparam int ADDR_W = 8;
   localparam logic [31:0] EN  = 32'h4000_0000;
   localparam logic [31:0] IE  = 32'h2000_0000;
   localparam logic [31:0] PER = 32'h0800_0000;
   localparam logic [31:0] RLD = 32'h0400_0000;
   localparam logic [31:0] ACT = 32'h0200_0000;
   localparam logic [7:0]  STAT = 8'h80;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NUM_CH-1:0] irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   tmr_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [7:0] a_ctrl(int c); return 8'(c * 16);     endfunction
   function automatic logic [7:0] a_init(int c); return 8'(c * 16 + 4); endfunction
   function automatic logic [7:0] a_cnt(int c);  return 8'(c * 16 + 8); endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_edges(int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(a_ctrl(0), v); chk("R1 ctrl", v, 32'h5);
      rd(a_init(1), v); chk("R1 init", v, 0);
      rd(a_cnt(2), v);  chk("R1 cnt", v, 0);
      rd(STAT, v);      chk("R1 stat", v, 0);
      chk("R1 irq", 32'(irq), 0);
   endtask

   task automatic t_oneshot();
      logic [31:0] v;
      wr(a_init(0), 5);
      wr(a_ctrl(0), EN | IE);
      wait_edges(3);
      rd(a_cnt(0), v); chk("R2 mid count", v, 2);
      wait_edges(2);
      rd(STAT, v);      chk("R3 status", v, 1);
      rd(a_ctrl(0), v); chk("R3 ctrl", v, IE);
      rd(a_cnt(0), v);  chk("R3 count", v, 0);
      chk("R10 irq on", 32'(irq), 1);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      wr(STAT, 0);
      rd(STAT, v); chk("R11 write0", v, 1);
      wr(STAT, 1);
      rd(STAT, v); chk("R11 write1", v, 0);
      chk("R10 irq off", 32'(irq), 0);
   endtask

   task automatic t_prescale();
      logic [31:0] v;
      wr(a_init(1), 4);
      wr(a_ctrl(1), EN | 32'd3);
      wait_edges(7);
      rd(a_cnt(1), v); chk("R2 div4 early", v, 3);
      wait_edges(1);
      rd(a_cnt(1), v); chk("R2 div4", v, 2);
      wr(a_ctrl(1), 32'd3);
   endtask

   task automatic t_pause();
      logic [31:0] v;
      wr(a_init(2), 10);
      wr(a_ctrl(2), EN);
      wait_edges(3);
      wr(a_ctrl(2), 0);
      rd(a_ctrl(2), v); chk("R7 act cleared", v, 0);
      wait_edges(5);
      rd(a_cnt(2), v); chk("R5 frozen", v, 7);
      wr(a_ctrl(2), EN);
      rd(a_ctrl(2), v); chk("R7 act set", v, EN | ACT);
      wait_edges(2);
      rd(a_cnt(2), v); chk("R5 resumed", v, 5);
      rd(STAT, v);     chk("R5 no event", v, 0);
   endtask

   task automatic t_reload();
      logic [31:0] v;
      wr(a_ctrl(2), EN | RLD | IE);
      rd(a_ctrl(2), v); chk("R6 ctrl", v, IE);
      rd(a_cnt(2), v);  chk("R6 reloaded", v, 10);
      wait_edges(3);
      rd(a_cnt(2), v);  chk("R6 stopped", v, 10);
      wr(a_ctrl(2), 0);
   endtask

   task automatic t_periodic();
      logic [31:0] v;
      wr(a_init(0), 3);
      wr(a_ctrl(0), EN | PER);
      wait_edges(3);
      rd(STAT, v);      chk("R4 status", v, 1);
      rd(a_cnt(0), v);  chk("R4 reload", v, 3);
      rd(a_ctrl(0), v); chk("R4 still on", v, EN | PER | ACT);
      wait_edges(1);
      rd(a_cnt(0), v);  chk("R4 next", v, 2);
      chk("R10 gated", 32'(irq), 0);
      wr(a_ctrl(0), EN | PER | IE);
      chk("R10 ie set", 32'(irq), 1);
      wr(a_ctrl(0), 0);
      wr(STAT, 1);
   endtask

   task automatic t_rate_change();
      logic [31:0] v;
      wr(a_init(1), 20);
      wr(a_ctrl(1), EN);
      wait_edges(2);
      wr(a_ctrl(1), EN | 32'd1);
      rd(a_cnt(1), v);  chk("R8 kept", v, 18);
      wait_edges(4);
      rd(a_cnt(1), v);  chk("R8 new rate", v, 16);
      rd(a_ctrl(1), v); chk("R8 ctrl", v, EN | ACT | 32'd1);
      wr(a_ctrl(1), 0);
   endtask

   task automatic t_init_write();
      logic [31:0] v;
      rd(a_cnt(1), v); chk("R8 held", v, 16);
      wr(a_cnt(1), 32'h55);
      rd(a_cnt(1), v); chk("R9 cnt ro", v, 16);
      wr(a_init(1), 9);
      rd(a_cnt(1), v);  chk("R9 loaded", v, 9);
      rd(a_init(1), v); chk("R9 init", v, 9);
   endtask

   task automatic t_reserved();
      logic [31:0] v;
      wr(a_ctrl(1), 32'h93FF_FF42);
      rd(a_ctrl(1), v); chk("R7 reserved", v, 32'h42);
   endtask

   task automatic t_stop_at_zero();
      logic [31:0] v;
      wr(a_init(2), 0);
      wr(a_ctrl(2), EN | 32'hFF);
      wr(a_ctrl(2), 32'hFF);
      rd(STAT, v); chk("R12 event", v, 4);
      chk("R10 no ie", 32'(irq), 0);
      wr(a_ctrl(2), IE);
      chk("R10 ie on", 32'(irq), 4);
      wr(STAT, 4);
      chk("R11 cleared", 32'(irq), 0);
   endtask

   task automatic t_clear_race();
      logic [31:0] v;
      wr(a_init(0), 1);
      wr(a_ctrl(0), EN | PER);
      wait_edges(2);
      wr(STAT, 1);
      rd(STAT, v); chk("R11 event wins", v, 1);
      wr(a_ctrl(0), 0);
      wr(STAT, 1);
      rd(STAT, v); chk("R11 clear", v, 0);
   endtask

   task automatic t_decode();
      logic [31:0] v;
      rd(8'h40, v); chk("R13 absent ch", v, 0);
      rd(8'h0C, v); chk("R13 hole", v, 0);
      rd(8'h84, v); chk("R13 past stat", v, 0);
      wr(8'h01, EN);
      rd(a_ctrl(0), v); chk("R13 unaligned", v, 0);
      wr(8'h40, EN);
      rd(a_ctrl(1), v); chk("R13 ch1 intact", v, 32'h42);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_oneshot();
      t_w1c();
      t_prescale();
      t_pause();
      t_reload();
      t_periodic();
      t_rate_change();
      t_init_write();
      t_reserved();
      t_stop_at_zero();
      t_clear_race();
      t_decode();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule